// File: doc/BRIEF.md
# Start/Stop Programmable Burst Pulse Generator

This block is a synchronous model of a self-looping delay-line oscillator. While it runs, it emits a train of pulses on `pulse_out`. Each pulse is one base-clock cycle wide. The spacing between pulses is a loop delay counted in base-clock cycles. A trigger on `start_trig` launches the train from idle, and a trigger on `stop_trig` halts it. The length of a burst therefore follows from the interval between the two triggers: roughly that interval divided by the period.

The loop delay comes from a small set of lengths. A select register picks the length, and each trigger on `sel_trig` steps it on cyclically, so the period can be changed at run time without rebuilding anything. A new length is adopted only when an interval ends, so no interval is ever cut short. A 16-bit counter reports how many pulses the current or most recent burst has produced, and it keeps that value after the burst ends.

Top module: `burst_pulse_gen`

## Requirements
- R1: After reset, `running` and `pulse_out` are 0, `burst_count` is 0 and the select register holds code 0.
- R2: A start trigger seen while idle sets `running` at the next clock edge. The first pulse rises exactly P edges later, where P is the period in force.
- R3: While running, consecutive pulses are exactly P cycles apart and each pulse is one cycle wide.
- R4: A stop trigger clears `running` at the next edge, and no pulse is emitted at or after that edge. This holds even if a pulse was due on that edge. Stop wins over a start in the same cycle. A stop while idle changes nothing.
- R5: A start trigger while running is ignored: the pulse phase and `burst_count` are unaffected.
- R6: `burst_count` clears when a burst starts and increments by one at the same edge as each pulse. When idle it holds its value.
- R7: Select codes 0, 1, 2 and 3 give periods of 2, 4, 8 and 16 cycles. Each select trigger advances the code by one, and code 3 wraps to 0. Triggers are accepted while idle and while running.
- R8: A period change takes effect only at a pulse boundary, so the interval in progress completes at its old length. The period of a new interval is the select code after any select trigger seen in the same cycle as that boundary, or in the same cycle as the accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_trig | input | 1 | One-cycle start trigger |
| stop_trig | input | 1 | One-cycle stop trigger |
| sel_trig | input | 1 | One-cycle period-select advance trigger |
| pulse_out | output | 1 | Pulse stream, one cycle per pulse |
| running | output | 1 | High while the oscillator runs |
| burst_count | output | 16 | Pulses emitted in the current or most recent burst |

## Verification
The hardest cases to reach from the ports are the ones where a trigger lands exactly on the edge at which a pulse is due. Two such cases matter: a select trigger in the boundary cycle, which must shape the very next interval, and a stop trigger in that cycle, which must suppress the pulse. The stimulus counts cycles from a known pulse to place those triggers on the boundary cycle. It places further triggers a few cycles into an interval to show that the old length is kept. A long run of sparse random triggers, compared every cycle against the reference model, then covers the remaining overlaps.

// File: rtl/burst_pulse_gen.sv
module burst_pulse_gen #(
  parameter int COUNT_W     = 16,
  parameter int NUM_PERIODS = 4,
  parameter int BASE_LOG2   = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_trig,
  input  logic               stop_trig,
  input  logic               sel_trig,
  output logic               pulse_out,
  output logic               running,
  output logic [COUNT_W-1:0] burst_count
);
  localparam int SEL_W = (NUM_PERIODS > 1) ? $clog2(NUM_PERIODS) : 1;
  localparam int PH_W  = BASE_LOG2 + NUM_PERIODS;
  localparam logic [SEL_W-1:0] SEL_TOP = SEL_W'(NUM_PERIODS - 1);

  logic [SEL_W-1:0] sel_q, sel_nxt, live_sel;
  logic [PH_W-1:0]  phase, live_last;
  logic             boundary, go;

  assign sel_nxt   = !sel_trig ? sel_q : (sel_q == SEL_TOP) ? '0 : sel_q + 1'b1;
  assign live_last = (PH_W'(1) << (BASE_LOG2 + int'(live_sel))) - 1'b1;
  assign boundary  = running && (phase == live_last);
  assign go        = start_trig && !running && !stop_trig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q       <= '0;
      live_sel    <= '0;
      phase       <= '0;
      running     <= 1'b0;
      pulse_out   <= 1'b0;
      burst_count <= '0;
    end else begin
      sel_q <= sel_nxt;
      if (stop_trig) begin
        running   <= 1'b0;
        pulse_out <= 1'b0;
        phase     <= '0;
      end else if (go) begin
        running     <= 1'b1;
        pulse_out   <= 1'b0;
        phase       <= '0;
        live_sel    <= sel_nxt;
        burst_count <= '0;
      end else if (boundary) begin
        pulse_out   <= 1'b1;
        phase       <= '0;
        live_sel    <= sel_nxt;
        burst_count <= burst_count + 1'b1;
      end else begin
        pulse_out <= 1'b0;
        if (running) phase <= phase + 1'b1;
      end
    end
  end

  AST_PULSE_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_out |=> !pulse_out); // R3
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !pulse_out); // R4
  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_trig |=> (!running && !pulse_out)); // R4
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !stop_trig) |=> running); // R5
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> (burst_count == '0 && !pulse_out)); // R6
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_out) |-> (burst_count == $past(burst_count) + 1'b1)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start_trig) |=> $stable(burst_count)); // R6
endmodule

// File: tb/burst_pulse_gen_test.sv
module burst_pulse_gen_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_t = 1'b0, stop_t = 1'b0, sel_t = 1'b0;
  logic pulse_out, running;
  logic [15:0] burst_count;
  int errors = 0, checks = 0;
  bit cmp_en = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_pulse_gen uut (
    .clk(clk), .rst_n(rst_n), .start_trig(start_t), .stop_trig(stop_t),
    .sel_trig(sel_t), .pulse_out(pulse_out), .running(running),
    .burst_count(burst_count)
  );

  // behavioural reference
  int m_sel, m_per, m_elapsed, m_count;
  bit m_run, m_pulse;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel = 0; m_per = 2; m_elapsed = 0; m_count = 0; m_run = 0; m_pulse = 0;
    end else begin
      int nsel;
      nsel = sel_t ? (m_sel + 1) % 4 : m_sel;
      m_pulse = 0;
      if (stop_t) begin
        m_run = 0;
      end else if (!m_run && start_t) begin
        m_run = 1; m_elapsed = 0; m_per = 2 << nsel; m_count = 0;
      end else if (m_run) begin
        m_elapsed++;
        if (m_elapsed == m_per) begin
          m_pulse = 1; m_elapsed = 0; m_per = 2 << nsel;
          m_count = (m_count + 1) % 65536;
        end
      end
      m_sel = nsel;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && cmp_en) begin
    chk("R3 pulse_out vs model", int'(pulse_out), int'(m_pulse));
    chk("R4 running vs model", int'(running), int'(m_run));
    chk("R6 burst_count vs model", int'(burst_count), m_count);
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic trig(bit s, bit p, bit q);
    start_t = s; stop_t = p; sel_t = q;
    tick();
    start_t = 0; stop_t = 0; sel_t = 0;
  endtask

  task automatic gap(output int n);
    n = 0;
    do begin tick(); n++; end while (!pulse_out && n < 40);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog R2: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n, c;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    cmp_en = 1'b1;
    chk("R1 running after reset", int'(running), 0);
    chk("R1 pulse after reset", int'(pulse_out), 0);
    chk("R1 count after reset", int'(burst_count), 0);

    trig(1, 0, 0);
    chk("R2 running after start", int'(running), 1);
    gap(n); chk("R2 first pulse latency (code 0 -> 2)", n, 2);
    chk("R6 count after first pulse", int'(burst_count), 1);
    gap(n); chk("R3 steady period 2", n, 2);

    c = int'(burst_count);
    trig(1, 0, 0);
    gap(n); chk("R5 phase kept on busy start", n, 1);
    chk("R5 count kept on busy start", int'(burst_count), c + 1);

    trig(0, 0, 1);
    gap(n); chk("R8 old interval completes", n, 1);
    gap(n); chk("R7 code 1 -> period 4", n, 4);

    tick(); tick();
    trig(0, 0, 1);
    gap(n); chk("R8 mid-interval change keeps length 4", n + 3, 4);
    gap(n); chk("R7 code 2 -> period 8", n, 8);

    repeat (7) tick();
    trig(0, 0, 1);
    chk("R8 pulse on boundary with select", int'(pulse_out), 1);
    gap(n); chk("R8 boundary select gives period 16", n, 16);

    trig(0, 0, 1);
    gap(n); chk("R8 16 interval completes after wrap", n + 1, 16);
    gap(n); chk("R7 wrap 3 -> 0 gives period 2", n, 2);

    tick();
    c = int'(burst_count);
    trig(0, 1, 0);
    chk("R4 stop suppresses due pulse", int'(pulse_out), 0);
    chk("R4 running cleared by stop", int'(running), 0);
    repeat (20) tick();
    chk("R6 count held after stop", int'(burst_count), c);

    trig(0, 1, 0);
    chk("R4 stop while idle", int'(running), 0);
    trig(1, 1, 0);
    chk("R4 stop wins over start", int'(running), 0);
    chk("R4 count untouched by stop+start", int'(burst_count), c);

    trig(1, 0, 0);
    chk("R6 count cleared on start", int'(burst_count), 0);
    gap(n); chk("R2 restart latency period 2", n, 2);

    repeat (3000) begin
      start_t = ($urandom_range(99) < 3);
      stop_t  = ($urandom_range(99) < 2);
      sel_t   = ($urandom_range(99) < 4);
      tick();
    end
    start_t = 0; stop_t = 0; sel_t = 0;
    repeat (5) tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule